// File: doc/BRIEF.md
# Register Data Stack with Nibble-Serial Literal Builder

This block is the operand stack of a small stack processor. The top element lives in its own register, which is twice the cell width. Below it sits a fixed number of cell-wide levels held in flip-flops, so the top and second elements are always visible without a memory read. The instruction decoder drives one strobe per stack operation. The block moves the whole stack, part of it, or only the top register in a single clock. Push, load-top, pop, double pop (for a store that consumes address and data), swap and literal construction each take one cycle.

The top register is written through a four-way source selector. Its sources are the second element, the ALU result, the current top shifted left by one nibble with a new nibble inserted, and the return-stack top. Constants are built without a full-width literal field in the instruction. A literal-start strobe pushes zero or all ones. Each following literal strobe then shifts the top left by four bits and inserts the nibble supplied with it. Deeper levels are not touched during this. An occupancy counter raises a one-cycle overflow or underflow flag on misuse. The data still moves, rotating through the levels, so behaviour stays defined.

Top module: `data_stack_lit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, tos reads 0, nos reads 0, and both overflow and underflow are low. The stack then holds no elements.
- R2: On a push, the top register takes the selected source and nos takes the low cell of the old top. Each deeper level takes the level above it. The bottom level is dropped. top_sel encodes the source: 2'b00 is nos zero-extended, 2'b01 is alu_result, 2'b10 is the old top shifted left 4 bits with lit_nibble ORed into bits 3:0, and 2'b11 is rstack_top zero-extended.
- R3: On a load-top, only the top register is written, from the source chosen by top_sel as in R2. nos and every deeper level keep their values.
- R4: On a pop, tos becomes nos zero-extended, so the upper half is discarded. Each level takes the level below it. The bottom level takes the low cell of the old top, so the levels rotate.
- R5: On a double pop, tos becomes the old third element zero-extended. The levels rotate up by two positions: the second-lowest level gets the old top's low cell and the lowest level gets the old nos.
- R6: On a swap, the low cell of tos and nos exchange in one cycle. The upper half of tos is cleared and deeper levels are unchanged.
- R7: Literal start pushes like R2, but with a value of 0 when lit_neg is 0 and all ones (32 bits) when lit_neg is 1. It also enters literal mode.
- R8: While literal mode is active, a literal strobe sets tos to (tos << 4) | lit_nibble over the full 32 bits. nos and deeper levels do not change.
- R9: Literal mode ends at the first cycle whose winning strobe is anything other than a literal strobe. Idle cycles keep it. A literal strobe outside literal mode changes nothing.
- R10: When several strobes are high together, only one acts, chosen in this order: double pop, pop, push, literal start, swap, load-top, literal.
- R11: A push or literal start while the stack holds all DEPTH+1 elements raises overflow for exactly the next cycle. The data still moves as R2 and the element count stays full.
- R12: A pop with no elements, or a double pop with fewer than two, raises underflow for exactly the next cycle. The levels still rotate and the count becomes 0.
- R13: The top register is 32 bits. A 32-bit alu_result is kept whole in tos, and a later push stores only its low 16 bits into nos.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_push | input | 1 | Push strobe |
| op_load | input | 1 | Load-top strobe |
| op_pop | input | 1 | Pop strobe |
| op_dpop | input | 1 | Double-pop strobe |
| op_swap | input | 1 | Swap strobe |
| op_lit_start | input | 1 | Literal start strobe |
| op_lit | input | 1 | Literal nibble strobe |
| top_sel | input | 2 | Top source select for push and load-top |
| lit_neg | input | 1 | Literal start value: 0 gives zero, 1 gives all ones |
| lit_nibble | input | 4 | Nibble inserted by shifts |
| alu_result | input | 32 | Double-width ALU result |
| rstack_top | input | 16 | Return-stack top cell |
| tos | output | 32 | Top register |
| nos | output | 16 | Second element |
| overflow | output | 1 | One-cycle overflow flag |
| underflow | output | 1 | One-cycle underflow flag |

## Verification
The bench targets the places where the top register and the deeper levels must move differently. A load-top or literal shift that enabled the deeper levels would corrupt nos. A swap that also shifted the deeper levels would lose the third element. Rotation at the bottom on pop and double pop is checked by draining the stack past empty: a design that filled with zeros would return wrong values on later pops. Full and empty boundaries, simultaneous strobes and literal strobes outside literal mode are driven directly. A design that got the count wrong, dropped the upper half of the ALU result, or kept literal mode alive across another operation would show a wrong flag or top value.

// File: rtl/ds_pkg.sv
package ds_pkg;

   typedef enum logic [2:0] {
      DS_IDLE      = 3'd0,
      DS_PUSH      = 3'd1,
      DS_LOAD      = 3'd2,
      DS_POP       = 3'd3,
      DS_DPOP      = 3'd4,
      DS_SWAP      = 3'd5,
      DS_LIT_START = 3'd6,
      DS_LIT       = 3'd7
   } ds_op_e;

   localparam logic [1:0] SRC_NOS = 2'b00;
   localparam logic [1:0] SRC_ALU = 2'b01;
   localparam logic [1:0] SRC_LIT = 2'b10;
   localparam logic [1:0] SRC_RS  = 2'b11;

   function automatic logic op_pushes(input ds_op_e op);
      return (op == DS_PUSH) || (op == DS_LIT_START);
   endfunction

endpackage

// File: rtl/ds_op_arbiter.sv
module ds_op_arbiter
   import ds_pkg::*;
(
   input  logic   s_push,
   input  logic   s_load,
   input  logic   s_pop,
   input  logic   s_dpop,
   input  logic   s_swap,
   input  logic   s_lit_start,
   input  logic   s_lit,
   input  logic   lit_mode,
   output ds_op_e op
);

   always_comb begin
      if (s_dpop)                 op = DS_DPOP;
      else if (s_pop)             op = DS_POP;
      else if (s_push)            op = DS_PUSH;
      else if (s_lit_start)       op = DS_LIT_START;
      else if (s_swap)            op = DS_SWAP;
      else if (s_load)            op = DS_LOAD;
      else if (s_lit && lit_mode) op = DS_LIT;
      else                        op = DS_IDLE;
   end

endmodule

// File: rtl/ds_top_path.sv
module ds_top_path
   import ds_pkg::*;
#(
   parameter int CELL_W = 16,
   parameter int NIB_W  = 4,
   localparam int TOP_W = 2 * CELL_W
)(
   input  ds_op_e            op,
   input  logic [1:0]        top_sel,
   input  logic              lit_neg,
   input  logic [NIB_W-1:0]  lit_nibble,
   input  logic [TOP_W-1:0]  alu_result,
   input  logic [CELL_W-1:0] rstack_top,
   input  logic [TOP_W-1:0]  tos_q,
   input  logic [CELL_W-1:0] lvl0,
   input  logic [CELL_W-1:0] lvl1,
   output logic [TOP_W-1:0]  tos_d,
   output logic              tos_en
);

   localparam int PAD_W = TOP_W - CELL_W;

   logic [TOP_W-1:0] shifted;
   logic [TOP_W-1:0] src_mux;

   always_comb begin
      shifted = (tos_q << NIB_W);
      shifted[NIB_W-1:0] = lit_nibble;
   end

   always_comb begin
      unique case (top_sel)
         SRC_NOS: src_mux = {{PAD_W{1'b0}}, lvl0};
         SRC_ALU: src_mux = alu_result;
         SRC_LIT: src_mux = shifted;
         default: src_mux = {{PAD_W{1'b0}}, rstack_top};
      endcase
   end

   always_comb begin
      tos_en = 1'b1;
      tos_d  = tos_q;
      unique case (op)
         DS_PUSH, DS_LOAD: tos_d = src_mux;
         DS_POP:           tos_d = {{PAD_W{1'b0}}, lvl0};
         DS_DPOP:          tos_d = {{PAD_W{1'b0}}, lvl1};
         DS_SWAP:          tos_d = {{PAD_W{1'b0}}, lvl0};
         DS_LIT_START:     tos_d = {TOP_W{lit_neg}};
         DS_LIT:           tos_d = shifted;
         default:          tos_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/ds_level_array.sv
module ds_level_array
   import ds_pkg::*;
#(
   parameter int CELL_W = 16,
   parameter int DEPTH  = 8
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  ds_op_e                       op,
   input  logic [CELL_W-1:0]            top_lo,
   output logic [DEPTH-1:0][CELL_W-1:0] lvl
);

   logic [DEPTH-1:0][CELL_W-1:0] lvl_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      localparam int ABOVE = (i == 0) ? 0 : i - 1;
      localparam int BELOW = (i == DEPTH - 1) ? 0 : i + 1;
      localparam int BELOW2 = (i + 2 < DEPTH) ? i + 2 : 0;

      logic [CELL_W-1:0] from_above;
      logic [CELL_W-1:0] from_below;
      logic [CELL_W-1:0] from_below2;
      logic [CELL_W-1:0] nxt;
      logic              en;

      if (i == 0) begin : g_first
         assign from_above = top_lo;
      end else begin : g_inner_a
         assign from_above = lvl_q[ABOVE];
      end

      if (i == DEPTH - 1) begin : g_last
         assign from_below  = top_lo;
         assign from_below2 = lvl_q[0];
      end else if (i == DEPTH - 2) begin : g_second_last
         assign from_below  = lvl_q[BELOW];
         assign from_below2 = top_lo;
      end else begin : g_inner_b
         assign from_below  = lvl_q[BELOW];
         assign from_below2 = lvl_q[BELOW2];
      end

      always_comb begin
         en  = 1'b1;
         nxt = lvl_q[i];
         unique case (op)
            DS_PUSH, DS_LIT_START: nxt = from_above;
            DS_POP:                nxt = from_below;
            DS_DPOP:               nxt = from_below2;
            DS_SWAP: begin
               en  = (i == 0);
               nxt = top_lo;
            end
            default: en = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  lvl_q[i] <= '0;
         else if (en) lvl_q[i] <= nxt;
      end
   end

   assign lvl = lvl_q;

endmodule

// File: rtl/ds_occupancy.sv
module ds_occupancy
   import ds_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int SLOTS = DEPTH + 1,
   localparam int CNT_W = $clog2(SLOTS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  ds_op_e           op,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             udf
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             ovf_d;
   logic             udf_d;

   always_comb begin
      cnt_d = cnt_q;
      ovf_d = 1'b0;
      udf_d = 1'b0;
      if (op_pushes(op)) begin
         if (cnt_q == FULL) ovf_d = 1'b1;
         else               cnt_d = cnt_q + ONE;
      end else if (op == DS_POP) begin
         if (cnt_q == '0) udf_d = 1'b1;
         else             cnt_d = cnt_q - ONE;
      end else if (op == DS_DPOP) begin
         if (cnt_q < TWO) begin
            udf_d = 1'b1;
            cnt_d = '0;
         end else begin
            cnt_d = cnt_q - TWO;
         end
      end else if (op == DS_LOAD) begin
         if (cnt_q == '0) cnt_d = ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf   <= 1'b0;
         udf   <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         ovf   <= ovf_d;
         udf   <= udf_d;
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/data_stack_lit.sv
module data_stack_lit
   import ds_pkg::*;
#(
   parameter int CELL_W = 16,
   parameter int DEPTH  = 8,
   parameter int NIB_W  = 4,
   localparam int TOP_W = 2 * CELL_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_push,
   input  logic              op_load,
   input  logic              op_pop,
   input  logic              op_dpop,
   input  logic              op_swap,
   input  logic              op_lit_start,
   input  logic              op_lit,
   input  logic [1:0]        top_sel,
   input  logic              lit_neg,
   input  logic [NIB_W-1:0]  lit_nibble,
   input  logic [TOP_W-1:0]  alu_result,
   input  logic [CELL_W-1:0] rstack_top,
   output logic [TOP_W-1:0]  tos,
   output logic [CELL_W-1:0] nos,
   output logic              overflow,
   output logic              underflow
);

   localparam int CNT_W = $clog2(DEPTH + 2);

   if (DEPTH < 2) begin : g_bad_depth
      $error("data_stack_lit: DEPTH must be at least 2");
   end
   if (NIB_W < 1 || NIB_W >= TOP_W) begin : g_bad_nib
      $error("data_stack_lit: NIB_W must lie in 1..TOP_W-1");
   end

   ds_op_e                       op;
   logic                         lit_mode_q;
   logic [TOP_W-1:0]             tos_q;
   logic [TOP_W-1:0]             tos_d;
   logic                         tos_en;
   logic [DEPTH-1:0][CELL_W-1:0] lvl;
   logic [CNT_W-1:0]             count;

   ds_op_arbiter u_arb (
      .s_push      (op_push),
      .s_load      (op_load),
      .s_pop       (op_pop),
      .s_dpop      (op_dpop),
      .s_swap      (op_swap),
      .s_lit_start (op_lit_start),
      .s_lit       (op_lit),
      .lit_mode    (lit_mode_q),
      .op          (op)
   );

   ds_top_path #(.CELL_W(CELL_W), .NIB_W(NIB_W)) u_top (
      .op         (op),
      .top_sel    (top_sel),
      .lit_neg    (lit_neg),
      .lit_nibble (lit_nibble),
      .alu_result (alu_result),
      .rstack_top (rstack_top),
      .tos_q      (tos_q),
      .lvl0       (lvl[0]),
      .lvl1       (lvl[1]),
      .tos_d      (tos_d),
      .tos_en     (tos_en)
   );

   ds_level_array #(.CELL_W(CELL_W), .DEPTH(DEPTH)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .top_lo (tos_q[CELL_W-1:0]),
      .lvl    (lvl)
   );

   ds_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .count (count),
      .ovf   (overflow),
      .udf   (underflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tos_q <= '0;
      else if (tos_en) tos_q <= tos_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     lit_mode_q <= 1'b0;
      else if (op == DS_LIT_START)    lit_mode_q <= 1'b1;
      else if (op != DS_IDLE && op != DS_LIT) lit_mode_q <= 1'b0;
   end

   assign tos = tos_q;
   assign nos = lvl[0];

   logic unused_count;
   assign unused_count = ^count;

endmodule

// File: rtl/ds_checker.sv
module ds_checker #(
   parameter int CELL_W = 16,
   parameter int NIB_W  = 4,
   localparam int TOP_W = 2 * CELL_W
)(
   input logic              clk,
   input logic              rst_n,
   input logic              op_push,
   input logic              op_load,
   input logic              op_pop,
   input logic              op_dpop,
   input logic              op_swap,
   input logic              op_lit_start,
   input logic              lit_neg,
   input logic [TOP_W-1:0]  tos,
   input logic [CELL_W-1:0] nos,
   input logic              overflow,
   input logic              underflow
);

   logic w_dpop, w_pop, w_push, w_lstart, w_swap, w_load;
   assign w_dpop   = op_dpop;
   assign w_pop    = op_pop && !op_dpop;
   assign w_push   = op_push && !op_pop && !op_dpop;
   assign w_lstart = op_lit_start && !op_push && !op_pop && !op_dpop;
   assign w_swap   = op_swap && !op_lit_start && !op_push && !op_pop && !op_dpop;
   assign w_load   = op_load && !op_swap && !op_lit_start && !op_push && !op_pop && !op_dpop;

   AST_PUSH_NOS: assert property (@(posedge clk) disable iff (!rst_n)
      w_push |=> nos == $past(tos[CELL_W-1:0])); // R2

   AST_LOAD_KEEPS_NOS: assert property (@(posedge clk) disable iff (!rst_n)
      w_load |=> $stable(nos)); // R3

   AST_POP_TOS: assert property (@(posedge clk) disable iff (!rst_n)
      w_pop |=> tos == {{CELL_W{1'b0}}, $past(nos)}); // R4

   AST_SWAP_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
      w_swap |=> (nos == $past(tos[CELL_W-1:0])) && (tos == {{CELL_W{1'b0}}, $past(nos)})); // R6

   AST_LIT_START_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      w_lstart |=> tos == {TOP_W{$past(lit_neg)}}); // R7

   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> $past(w_push || w_lstart)); // R11

   AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> $past(w_pop || w_dpop)); // R12

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(overflow && underflow)); // R12

endmodule

bind data_stack_lit ds_checker #(.CELL_W(CELL_W), .NIB_W(NIB_W)) u_ds_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_push      (op_push),
   .op_load      (op_load),
   .op_pop       (op_pop),
   .op_dpop      (op_dpop),
   .op_swap      (op_swap),
   .op_lit_start (op_lit_start),
   .lit_neg      (lit_neg),
   .tos          (tos),
   .nos          (nos),
   .overflow     (overflow),
   .underflow    (underflow)
);

// File: tb/data_stack_lit_bench.sv
`timescale 1ns/1ps
module data_stack_lit_bench;

   localparam int CW = 16;
   localparam int TW = 32;
   localparam int DP = 8;

   localparam logic [6:0] K_PUSH  = 7'b0000001;
   localparam logic [6:0] K_LOAD  = 7'b0000010;
   localparam logic [6:0] K_POP   = 7'b0000100;
   localparam logic [6:0] K_DPOP  = 7'b0001000;
   localparam logic [6:0] K_SWAP  = 7'b0010000;
   localparam logic [6:0] K_LSTRT = 7'b0100000;
   localparam logic [6:0] K_LIT   = 7'b1000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_push = 0, op_load = 0, op_pop = 0, op_dpop = 0;
   logic op_swap = 0, op_lit_start = 0, op_lit = 0;
   logic [1:0]    top_sel = 0;
   logic          lit_neg = 0;
   logic [3:0]    lit_nibble = 0;
   logic [TW-1:0] alu_result = 0;
   logic [CW-1:0] rstack_top = 0;
   logic [TW-1:0] tos;
   logic [CW-1:0] nos;
   logic          overflow, underflow;

   always #2.5 clk = ~clk;

   data_stack_lit u_data_stack_lit (
      .clk(clk), .rst_n(rst_n),
      .op_push(op_push), .op_load(op_load), .op_pop(op_pop), .op_dpop(op_dpop),
      .op_swap(op_swap), .op_lit_start(op_lit_start), .op_lit(op_lit),
      .top_sel(top_sel), .lit_neg(lit_neg), .lit_nibble(lit_nibble),
      .alu_result(alu_result), .rstack_top(rstack_top),
      .tos(tos), .nos(nos), .overflow(overflow), .underflow(underflow)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   logic [TW-1:0] m_tos;
   logic [CW-1:0] m_stk [DP];
   int            m_cnt;
   bit            m_lit;
   bit            m_ovf, m_udf;

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         summary();
      end
   end

   task automatic chk(string tag, string what, logic [TW-1:0] act, logic [TW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [TW-1:0] shl_nib(logic [TW-1:0] v, logic [3:0] n);
      return {v[TW-5:0], n};
   endfunction

   function automatic logic [TW-1:0] pick_src(logic [1:0] s, logic [3:0] n,
                                              logic [TW-1:0] a, logic [CW-1:0] r);
      case (s)
         2'b00:   return {16'h0, m_stk[0]};
         2'b01:   return a;
         2'b10:   return shl_nib(m_tos, n);
         default: return {16'h0, r};
      endcase
   endfunction

   task automatic m_push(logic [TW-1:0] v);
      for (int i = DP - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
      m_stk[0] = m_tos[CW-1:0];
      m_tos = v;
      if (m_cnt == DP + 1) m_ovf = 1; else m_cnt++;
   endtask

   task automatic model(logic [6:0] k, logic [1:0] s, logic ng, logic [3:0] n,
                        logic [TW-1:0] a, logic [CW-1:0] r, output string tag);
      logic [CW-1:0] t0, t1;
      m_ovf = 0;
      m_udf = 0;
      if (k[3]) begin
         tag = "R5";
         t0 = m_tos[CW-1:0];
         t1 = m_stk[0];
         m_tos = {16'h0, m_stk[1]};
         for (int i = 0; i < DP - 2; i++) m_stk[i] = m_stk[i+2];
         m_stk[DP-2] = t0;
         m_stk[DP-1] = t1;
         if (m_cnt < 2) begin m_udf = 1; m_cnt = 0; end else m_cnt -= 2;
         m_lit = 0;
      end else if (k[2]) begin
         tag = "R4";
         t0 = m_tos[CW-1:0];
         m_tos = {16'h0, m_stk[0]};
         for (int i = 0; i < DP - 1; i++) m_stk[i] = m_stk[i+1];
         m_stk[DP-1] = t0;
         if (m_cnt == 0) m_udf = 1; else m_cnt--;
         m_lit = 0;
      end else if (k[0]) begin
         tag = (s == 2'b01) ? "R13" : "R2";
         m_push(pick_src(s, n, a, r));
         m_lit = 0;
      end else if (k[5]) begin
         tag = "R7";
         m_push({TW{ng}});
         m_lit = 1;
      end else if (k[4]) begin
         tag = "R6";
         t0 = m_tos[CW-1:0];
         m_tos = {16'h0, m_stk[0]};
         m_stk[0] = t0;
         m_lit = 0;
      end else if (k[1]) begin
         tag = "R3";
         m_tos = pick_src(s, n, a, r);
         if (m_cnt == 0) m_cnt = 1;
         m_lit = 0;
      end else if (k[6]) begin
         if (m_lit) begin tag = "R8"; m_tos = shl_nib(m_tos, n); end
         else tag = "R9";
      end else begin
         tag = "R9";
      end
      if ($countones(k) > 1) tag = "R10";
   endtask

   task automatic step(logic [6:0] k, logic [1:0] s, logic ng, logic [3:0] n,
                       logic [TW-1:0] a, logic [CW-1:0] r);
      string tag;
      @(negedge clk);
      {op_lit, op_lit_start, op_swap, op_dpop, op_pop, op_load, op_push} = k;
      top_sel = s; lit_neg = ng; lit_nibble = n; alu_result = a; rstack_top = r;
      @(posedge clk);
      #1;
      model(k, s, ng, n, a, r, tag);
      chk(tag, "tos", tos, m_tos);
      chk(tag, "nos", {16'h0, nos}, {16'h0, m_stk[0]});
      chk("R11", "overflow", {31'h0, overflow}, {31'h0, m_ovf});
      chk("R12", "underflow", {31'h0, underflow}, {31'h0, m_udf});
   endtask

   task automatic simple(logic [6:0] k, logic [1:0] s);
      step(k, s, 1'b0, 4'h0, 32'hA5A5_0000, 16'h0);
   endtask

   initial begin
      void'($urandom(32'd20240517));
      m_tos = '0; m_cnt = 0; m_lit = 0; m_ovf = 0; m_udf = 0;
      for (int i = 0; i < DP; i++) m_stk[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "tos in reset", tos, 32'h0);
      chk("R1", "flags in reset", {30'h0, overflow, underflow}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1", "tos after reset", tos, 32'h0);
      chk("R1", "nos after reset", {16'h0, nos}, 32'h0);

      // R12: underflow on empty, data still rotates
      simple(K_POP, 2'b00);
      simple(K_DPOP, 2'b00);
      // R2 / R11: fill with distinct rstack values, then overflow
      for (int i = 0; i < DP + 3; i++)
         step(K_PUSH, 2'b11, 1'b0, 4'h0, 32'h0, 16'h1100 + 16'(i));
      // R4: drain past empty to see bottom rotation
      for (int i = 0; i < DP + 3; i++) simple(K_POP, 2'b00);
      // R13: full-width ALU value, then push
      step(K_LOAD, 2'b01, 1'b0, 4'h0, 32'hDEAD_BEEF, 16'h0);
      step(K_PUSH, 2'b01, 1'b0, 4'h0, 32'h1234_5678, 16'h0);
      // R7 / R8: positive literal 0x1234
      step(K_LSTRT, 2'b00, 1'b0, 4'h0, 32'h0, 16'h0);
      for (int i = 1; i <= 4; i++) step(K_LIT, 2'b00, 1'b0, 4'(i), 32'h0, 16'h0);
      // idle keeps literal mode, then negative literal
      simple(7'b0, 2'b00);
      step(K_LIT, 2'b00, 1'b0, 4'h5, 32'h0, 16'h0);
      step(K_LSTRT, 2'b00, 1'b1, 4'h0, 32'h0, 16'h0);
      step(K_LIT, 2'b00, 1'b0, 4'hA, 32'h0, 16'h0);
      // R9: swap ends literal mode; later literal strobe ignored
      simple(K_SWAP, 2'b00);
      step(K_LIT, 2'b00, 1'b0, 4'hF, 32'h0, 16'h0);
      // R10: simultaneous strobes
      simple(K_PUSH | K_POP, 2'b01);
      simple(K_LOAD | K_SWAP, 2'b01);
      simple(K_DPOP | K_PUSH | K_LIT, 2'b01);

      for (int c = 0; c < 3000; c++) begin
         logic [6:0] k;
         int w = $urandom_range(0, 99);
         if (w < 70)      k = 7'(1 << $urandom_range(0, 6));
         else if (w < 85) k = 7'($urandom_range(0, 127));
         else if (w < 90) k = 7'b0;
         else             k = K_LIT;
         step(k, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              4'($urandom_range(0, 15)), $urandom, 16'($urandom));
      end

      summary();
   end

endmodule